// File: doc/BRIEF.md
# Permission-Tracked Set-Associative Tag Directory

This block is the tag side of a set-associative coherent cache. Each way of each set holds a line address and a two-bit access permission, and each set keeps a true-LRU age per way. It takes one command per clock and answers it one clock later. The commands are:

- a permission-checked access
- a presence test
- an availability check
- allocate and deallocate
- a permission overwrite
- a victim probe
- an explicit recency touch

Data storage, refill and protocol sequencing sit outside the block. A controller uses the answers to decide whether a request can proceed, where a new line goes, and which resident line must be evicted first.

The set index is the low `SET_BITS` bits of the line address. The full line address is stored as the tag. An entry counts as resident when its permission is anything other than "not present". A tag match alone does not grant access: the stored permission must also allow the request type.

Top module: `perm_tag_dir`

## Requirements
- R1: After reset, every way of every set holds line address 0 with permission NotPresent. A presence test therefore misses and an availability check succeeds for any line. The recency order at reset ranks way WAYS-1 least recent and way 0 most recent.
- R2: A command presented with `cmd_valid`=1 is answered on the outputs in the following cycle with `rsp_valid`=1. Without a command, `rsp_valid` is 0 the next cycle. Opcodes are: 0 access, 1 presence test, 2 availability, 3 allocate, 4 deallocate, 5 set permission, 6 victim probe, 7 touch.
- R3: A way matches when its stored line equals `cmd_line` and its permission is not NotPresent. A presence test returns `rsp_hit`=1 and the matching way in `rsp_way`, or `rsp_hit`=0 and way 0.
- R4: Permission codes are 0 NotPresent, 1 Invalid, 2 ReadOnly, 3 ReadWrite. Request codes are 0 load, 1 instruction fetch, 2 store (3 behaves as store). An access hits when the matching line is ReadWrite, or when it is ReadOnly and the request is a load or fetch. Otherwise the access misses with `rsp_error`=0.
- R5: An access that finds a matching way makes that way most recently used, even when the permission check reports a miss.
- R6: The availability check returns `rsp_hit`=1 when any way of the set holds `cmd_line` regardless of permission, or when any way is NotPresent.
- R7: Allocate of a line that is not resident fills the lowest-numbered NotPresent way. It writes the line, sets permission Invalid, makes that way most recently used, and returns `rsp_hit`=1 with that way. If the line is already resident or no way is free, allocate returns `rsp_error`=1.
- R8: Deallocate of a resident line sets its permission to NotPresent and returns the way. Deallocate of a non-resident line returns `rsp_error`=1.
- R9: Set permission overwrites the permission of a resident line with `cmd_perm` without changing recency. On a non-resident line it returns `rsp_error`=1.
- R10: Touch makes a resident line's way most recently used. On a non-resident line it returns `rsp_error`=1.
- R11: A victim probe in a set with no free way and no line equal to `cmd_line` returns `rsp_hit`=1, the least recently used way in `rsp_way`, and that way's stored line in `rsp_victim`. A probe anywhere else returns `rsp_error`=1. A probe never changes state.
- R12: A command that returns `rsp_error`=1 has `rsp_hit`=0 and changes no line, permission or recency. `rsp_way` and `rsp_victim` are 0 whenever the operation does not define them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_line | input | LINE_W | Line address of the command |
| cmd_req | input | 2 | Request type for access |
| cmd_perm | input | 2 | New permission for set permission |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Hit, success or availability result |
| rsp_way | output | WAY_W | Matched, allocated or victim way |
| rsp_victim | output | LINE_W | Stored line of the probed victim |
| rsp_error | output | 1 | Illegal command, nothing changed |

## Verification
The bench builds the block with SET_BITS=2, WAYS=4 and LINE_W=8, and draws lines from six candidates per set. With only four sets, random traffic keeps filling them completely. That brings full-set allocate errors, legal victim probes and LRU reordering within reach in nearly every stretch of the run. Reusing the same few lines also makes tag matches on NotPresent ways frequent, which separates the availability check from the presence test.

// File: rtl/tdir_pkg.sv
package tdir_pkg;

    typedef enum logic [2:0] {
        OP_ACCESS  = 3'd0,
        OP_TEST    = 3'd1,
        OP_AVAIL   = 3'd2,
        OP_ALLOC   = 3'd3,
        OP_DEALLOC = 3'd4,
        OP_SETPERM = 3'd5,
        OP_PROBE   = 3'd6,
        OP_TOUCH   = 3'd7
    } tdir_op_e;

    localparam logic [1:0] PERM_NP  = 2'd0;
    localparam logic [1:0] PERM_INV = 2'd1;
    localparam logic [1:0] PERM_RO  = 2'd2;
    localparam logic [1:0] PERM_RW  = 2'd3;

    // request bit 1 set means a write-type request
    function automatic logic perm_allows(input logic [1:0] perm, input logic [1:0] req);
        return (perm == PERM_RW) || ((perm == PERM_RO) && !req[1]);
    endfunction

endpackage

// File: rtl/tdir_match.sv
module tdir_match #(
    parameter int WAYS   = 4,
    parameter int LINE_W = 16,
    parameter int WAY_W  = 2
) (
    input  logic [WAYS-1:0][LINE_W-1:0] way_line,
    input  logic [WAYS-1:0][1:0]        way_perm,
    input  logic [LINE_W-1:0]           line,
    output logic [WAYS-1:0]             hit_vec,
    output logic [WAYS-1:0]             tag_eq_vec,
    output logic [WAYS-1:0]             free_vec,
    output logic [WAY_W-1:0]            hit_way,
    output logic [WAY_W-1:0]            free_way,
    output logic                        any_hit,
    output logic                        any_free
);
    import tdir_pkg::*;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tag_eq_vec[w] = (way_line[w] == line);
        assign free_vec[w]   = (way_perm[w] == PERM_NP);
        assign hit_vec[w]    = tag_eq_vec[w] && !free_vec[w];
    end

    assign any_hit  = |hit_vec;
    assign any_free = |free_vec;

    // lowest index wins: scan downwards so the last write is the lowest
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])  hit_way  = WAY_W'(w);
            if (free_vec[w]) free_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/tdir_lru.sv
module tdir_lru #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_in,
    input  logic                       touch_en,
    input  logic [WAY_W-1:0]           touch_way,
    output logic [WAYS-1:0][WAY_W-1:0] age_out,
    output logic [WAY_W-1:0]           victim_way
);
    logic [WAY_W-1:0] touched_age;

    assign touched_age = age_in[touch_way];

    // age 0 is most recent, WAYS-1 is least recent
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            age_out[w] = age_in[w];
            if (touch_en) begin
                if (WAY_W'(w) == touch_way) begin
                    age_out[w] = '0;
                end else if (age_in[w] < touched_age) begin
                    age_out[w] = age_in[w] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_in[w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/perm_tag_dir.sv
module perm_tag_dir #(
    parameter int SET_BITS = 3,
    parameter int WAYS     = 4,
    parameter int LINE_W   = 16,
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [LINE_W-1:0] cmd_line,
    input  logic [1:0]        cmd_req,
    input  logic [1:0]        cmd_perm,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [LINE_W-1:0] rsp_victim,
    output logic              rsp_error
);
    import tdir_pkg::*;

    localparam int SETS = 1 << SET_BITS;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][LINE_W-1:0] line;
        logic [SETS-1:0][WAYS-1:0][1:0]        perm;
        logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  age;
        logic                                  rsp_valid;
        logic                                  rsp_hit;
        logic                                  rsp_error;
        logic [WAY_W-1:0]                      rsp_way;
        logic [LINE_W-1:0]                     rsp_victim;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < SETS; i++) begin
            for (int w = 0; w < WAYS; w++) begin
                s.age[i][w] = WAY_W'(w);
            end
        end
        return s;
    endfunction

    state_t s_d, s_q;

    logic [SET_BITS-1:0] set_idx;
    tdir_op_e            op;
    logic [WAYS-1:0]     hit_vec, tag_eq_vec, free_vec;
    logic [WAY_W-1:0]    hit_way, free_way, victim_way, touch_way;
    logic                any_hit, any_free, touch_en;
    logic [WAYS-1:0][WAY_W-1:0] age_next;

    assign set_idx = cmd_line[SET_BITS-1:0];
    assign op      = tdir_op_e'(cmd_op);

    tdir_match #(.WAYS(WAYS), .LINE_W(LINE_W), .WAY_W(WAY_W)) u_match (
        .way_line   (s_q.line[set_idx]),
        .way_perm   (s_q.perm[set_idx]),
        .line       (cmd_line),
        .hit_vec    (hit_vec),
        .tag_eq_vec (tag_eq_vec),
        .free_vec   (free_vec),
        .hit_way    (hit_way),
        .free_way   (free_way),
        .any_hit    (any_hit),
        .any_free   (any_free)
    );

    // recency update request, decoded apart from the next-state logic
    always_comb begin
        touch_en  = 1'b0;
        touch_way = hit_way;
        if (cmd_valid) begin
            unique case (op)
                OP_ACCESS, OP_TOUCH: touch_en = any_hit;
                OP_ALLOC: begin
                    touch_en  = !any_hit && any_free;
                    touch_way = free_way;
                end
                default: touch_en = 1'b0;
            endcase
        end
    end

    tdir_lru #(.WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
        .age_in     (s_q.age[set_idx]),
        .touch_en   (touch_en),
        .touch_way  (touch_way),
        .age_out    (age_next),
        .victim_way (victim_way)
    );

    always_comb begin
        s_d            = s_q;
        s_d.rsp_valid  = cmd_valid;
        s_d.rsp_hit    = 1'b0;
        s_d.rsp_error  = 1'b0;
        s_d.rsp_way    = '0;
        s_d.rsp_victim = '0;
        if (cmd_valid) begin
            s_d.age[set_idx] = age_next;
            unique case (op)
                OP_ACCESS: begin
                    if (any_hit) begin
                        s_d.rsp_way = hit_way;
                        s_d.rsp_hit = perm_allows(s_q.perm[set_idx][hit_way], cmd_req);
                    end
                end
                OP_TEST: begin
                    s_d.rsp_hit = any_hit;
                    s_d.rsp_way = any_hit ? hit_way : '0;
                end
                OP_AVAIL: s_d.rsp_hit = (|tag_eq_vec) || any_free;
                OP_ALLOC: begin
                    if (!any_hit && any_free) begin
                        s_d.line[set_idx][free_way] = cmd_line;
                        s_d.perm[set_idx][free_way] = PERM_INV;
                        s_d.rsp_hit = 1'b1;
                        s_d.rsp_way = free_way;
                    end else begin
                        s_d.rsp_error = 1'b1;
                    end
                end
                OP_DEALLOC, OP_SETPERM, OP_TOUCH: begin
                    if (any_hit) begin
                        if (op == OP_DEALLOC) s_d.perm[set_idx][hit_way] = PERM_NP;
                        if (op == OP_SETPERM) s_d.perm[set_idx][hit_way] = cmd_perm;
                        s_d.rsp_hit = 1'b1;
                        s_d.rsp_way = hit_way;
                    end else begin
                        s_d.rsp_error = 1'b1;
                    end
                end
                OP_PROBE: begin
                    if (!(|tag_eq_vec) && !any_free) begin
                        s_d.rsp_hit    = 1'b1;
                        s_d.rsp_way    = victim_way;
                        s_d.rsp_victim = s_q.line[set_idx][victim_way];
                    end else begin
                        s_d.rsp_error = 1'b1;
                    end
                end
                default: s_d.rsp_error = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign rsp_valid  = s_q.rsp_valid;
    assign rsp_hit    = s_q.rsp_hit;
    assign rsp_way    = s_q.rsp_way;
    assign rsp_victim = s_q.rsp_victim;
    assign rsp_error  = s_q.rsp_error;

    // ages of the addressed set must stay a permutation of 0..WAYS-1
    logic [(1<<WAY_W)-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int w = 0; w < WAYS; w++) age_seen[s_q.age[set_idx][w]] = 1'b1;
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid); // R2
    AST_ERR_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> !rsp_hit); // R12
    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error) |-> (s_q.line == $past(s_q.line) && s_q.perm == $past(s_q.perm) && s_q.age == $past(s_q.age))); // R12
    AST_STORE_NEEDS_RW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_valid && cmd_op == OP_ACCESS && cmd_req[1]) && rsp_hit) |-> (s_q.perm[$past(set_idx)][rsp_way] == PERM_RW)); // R4
    AST_NO_DUP_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R3
    AST_LRU_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(age_seen) == WAYS); // R5
    AST_PROBE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_valid && cmd_op == OP_PROBE) |-> (s_q.perm == $past(s_q.perm) && s_q.age == $past(s_q.age))); // R11

endmodule

// File: tb/perm_tag_dir_test.sv
`timescale 1ns/1ps
module perm_tag_dir_test;
    localparam int SB = 2;
    localparam int W  = 4;
    localparam int LW = 8;
    localparam int SETS = 1 << SB;
    localparam int WW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [LW-1:0] cmd_line = '0;
    logic [1:0]    cmd_req = '0;
    logic [1:0]    cmd_perm = '0;
    logic          rsp_valid, rsp_hit, rsp_error;
    logic [WW-1:0] rsp_way;
    logic [LW-1:0] rsp_victim;

    always #2.5 clk = ~clk;

    perm_tag_dir #(.SET_BITS(SB), .WAYS(W), .LINE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_line(cmd_line), .cmd_req(cmd_req), .cmd_perm(cmd_perm),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_victim(rsp_victim), .rsp_error(rsp_error)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_line [SETS][W];
    int m_perm [SETS][W];
    int m_stamp[SETS][W];
    int stamp_ctr = 0;

    function automatic string tag_of(input int op, input bit err);
        if (err) return "R12";
        case (op)
            0: return "R4";
            1: return "R3";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5: return "R9";
            6: return "R11";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", rq, act, exp);
        end
    endtask

    // starts just after a falling edge; returns at the next falling edge
    task automatic cmd(input int op, input int line, input int req, input int perm, input string rq_override);
        int s = line % SETS;
        int hw = -1, fw = -1, vw = 0;
        bit teq = 0;
        bit eh = 0, ee = 0;
        int ew = 0, ev = 0;
        string rq;
        for (int w = 0; w < W; w++) begin
            if (m_line[s][w] == line && m_perm[s][w] != 0 && hw < 0) hw = w;
            if (m_line[s][w] == line) teq = 1;
            if (m_perm[s][w] == 0 && fw < 0) fw = w;
            if (m_stamp[s][w] < m_stamp[s][vw]) vw = w;
        end
        case (op)
            0: if (hw >= 0) begin
                   ew = hw;
                   eh = (m_perm[s][hw] == 3) || (m_perm[s][hw] == 2 && req < 2);
                   m_stamp[s][hw] = ++stamp_ctr;
               end
            1: if (hw >= 0) begin eh = 1; ew = hw; end
            2: eh = teq || (fw >= 0);
            3: if (hw < 0 && fw >= 0) begin
                   eh = 1; ew = fw;
                   m_line[s][fw] = line; m_perm[s][fw] = 1;
                   m_stamp[s][fw] = ++stamp_ctr;
               end else ee = 1;
            4: if (hw >= 0) begin eh = 1; ew = hw; m_perm[s][hw] = 0; end else ee = 1;
            5: if (hw >= 0) begin eh = 1; ew = hw; m_perm[s][hw] = perm; end else ee = 1;
            6: if (!teq && fw < 0) begin eh = 1; ew = vw; ev = m_line[s][vw]; end else ee = 1;
            default: if (hw >= 0) begin eh = 1; ew = hw; m_stamp[s][hw] = ++stamp_ctr; end else ee = 1;
        endcase
        rq = (rq_override != "") ? rq_override : tag_of(op, ee);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_line  = LW'(line);
        cmd_req   = 2'(req);
        cmd_perm  = 2'(perm);
        @(negedge clk);
        check(rsp_valid === 1'b1 && rsp_hit === eh && rsp_error === ee &&
              rsp_way === WW'(ew) && rsp_victim === LW'(ev),
              $sformatf("%s op%0d line%0d", rq, op, line),
              $sformatf("v%0b h%0b e%0b w%0d vic%0d", rsp_valid, rsp_hit, rsp_error, rsp_way, rsp_victim),
              $sformatf("v1 h%0b e%0b w%0d vic%0d", eh, ee, ew, ev));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < W; w++) begin
                m_line[s][w] = 0; m_perm[s][w] = 0; m_stamp[s][w] = -w;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_hit === 1'b0 && rsp_error === 1'b0,
              "R1 reset outputs", $sformatf("v%0b h%0b e%0b", rsp_valid, rsp_hit, rsp_error), "v0 h0 e0");

        // R1: empty directory
        cmd(1, 5, 0, 0, "R1");
        cmd(2, 5, 0, 0, "R1");
        cmd(1, 0, 0, 0, "R1");
        cmd(6, 5, 0, 0, "R1");
        // R7: fill set 1, ways 0..3, then overflow
        cmd(3, 1, 0, 0, "");
        cmd(3, 5, 0, 0, "");
        cmd(3, 9, 0, 0, "");
        cmd(3, 13, 0, 0, "");
        cmd(3, 17, 0, 0, "R7");
        cmd(3, 5, 0, 0, "R7");
        cmd(6, 17, 0, 0, "R11");
        // R4/R5: readonly line, store misses but still refreshes recency
        cmd(5, 1, 0, 2, "R9");
        cmd(0, 1, 2, 0, "R4");
        cmd(6, 17, 0, 0, "R5");
        cmd(0, 1, 0, 0, "R4");
        cmd(0, 1, 1, 0, "R4");
        cmd(0, 5, 0, 0, "R4");
        cmd(5, 9, 0, 3, "R9");
        cmd(0, 9, 2, 0, "R4");
        cmd(7, 5, 0, 0, "R10");
        cmd(6, 17, 0, 0, "R10");
        cmd(6, 5, 0, 0, "R11");
        cmd(7, 21, 0, 0, "R10");
        // R8: deallocate then refill into the freed way
        cmd(4, 9, 0, 0, "R8");
        cmd(1, 9, 0, 0, "R8");
        cmd(2, 17, 0, 0, "R6");
        cmd(3, 17, 0, 0, "R8");
        cmd(4, 21, 0, 0, "R8");
        cmd(5, 25, 0, 3, "R9");

        for (int i = 0; i < 4000; i++) begin
            int r   = int'($urandom_range(0, 99));
            int op  = (r < 30) ? 3 : (r < 40) ? 4 : int'($urandom_range(0, 7));
            int ln  = int'($urandom_range(0, 5)) * SETS + int'($urandom_range(0, SETS - 1));
            cmd(op, ln, int'($urandom_range(0, 2)), int'($urandom_range(0, 3)), "");
        end

        cmd_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R2 idle", $sformatf("v%0b", rsp_valid), "v0");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule